// File: doc/BRIEF.md
# Banked data memory decoder

This block is the data-space front end of a small microcontroller core. Each access arrives as a 7-bit register offset taken from the instruction word plus a single bank-select bit from the status register. The block joins the two into an 8-bit data address. It then sends the access to one of three targets: the special-function-register file outside the block, the general-purpose static RAM held inside it, or an unimplemented hole.

Both banks keep their special-function registers at the lowest 32 offsets. Above those, bank 0 holds RAM up to the top of the bank. Bank 1 holds its own RAM in a middle band. Its top sixteen bytes are not separate storage: they fold back onto the last sixteen bytes of bank-0 RAM, so a variable placed there can be reached without changing the bank bit. Reads of a hole return zero, and writes to a hole do nothing. The edges of the RAM bands are parameters, so a smaller variant of the part can be built from the same source.

Top module: `dmem_bank_decoder`

## Requirements
- R1: `sfr_addr` always carries the full data address, with the bank bit at bit 7 and the offset at bits 6:0.
- R2: For offsets 00h–1Fh in either bank, `rd_data` equals `sfr_rd_data` and `sfr_wr_en` follows `wr_en`. At every other offset, `sfr_wr_en` stays low.
- R3: In bank 0, offsets from `B0_RAM_LO` (default 20h) up to 7Fh are read/write RAM.
- R4: In bank 1, addresses A0h up to 80h+`B1_RAM_HI` (default EFh) are read/write RAM, kept apart from all bank-0 storage.
- R5: Bank-1 addresses F0h–FFh and bank-0 addresses 70h–7Fh are the same bytes, in both directions of access.
- R6: A read of any location that is neither a special-function register nor RAM returns 00h.
- R7: A write to an unimplemented location changes no RAM byte.
- R8: A RAM write takes effect on the rising clock edge. Before that edge, `rd_data` still shows the old byte at the addressed location.
- R9: While `rst_n` is low, no RAM write takes place and `sfr_wr_en` stays low.
- R10: Reset does not clear the RAM. Bytes written before reset read back unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes occur on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks all writes while low |
| bank_sel | input | 1 | Bank select: 0 for bank 0, 1 for bank 1 |
| offset | input | 7 | Register offset within the bank |
| wr_en | input | 1 | Write request for the current address |
| wr_data | input | 8 | Write data, shared with the special-function-register file |
| rd_data | output | 8 | Read data for the current address (combinational) |
| sfr_addr | output | 8 | Full data address towards the special-function-register file |
| sfr_wr_en | output | 1 | Write strobe towards the special-function-register file |
| sfr_rd_data | input | 8 | Read data returned by the special-function-register file |

## Verification
The clocked checks assume that `bank_sel`, `offset`, `wr_en` and `wr_data` are settled across each rising edge. The read-back and aliasing checks assume the written byte can only be observed on the cycle right after the write, if the address has not moved by then. The reset check assumes that the inputs are already defined at the first edge. The bench meets these assumptions by changing every input only on falling edges and by driving known values from time zero. Every address is swept in ascending and then descending order, so the alias window is last written from each side once. Two configurations are run side by side: the default one, and a reduced one that opens holes in both banks.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        RGN_SFR  = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

endpackage

// File: rtl/dmem_addr_decode.sv
module dmem_addr_decode
    import dmem_pkg::*;
#(
    parameter int OFS_W     = 7,
    parameter int SFR_CNT   = 32,
    parameter int B0_RAM_LO = 32,
    parameter int B1_RAM_HI = 111,
    parameter int MIRROR_LO = 112,
    parameter int IDX_W     = 8
) (
    input  logic             bank_sel,
    input  logic [OFS_W-1:0] offset,
    output region_e          region,
    output logic [IDX_W-1:0] ram_idx
);

    localparam int OFS_SPAN = 1 << OFS_W;
    localparam int B0_SPAN  = OFS_SPAN - B0_RAM_LO;

    localparam logic [OFS_W-1:0] SFR_END_O = OFS_W'(SFR_CNT);
    localparam logic [OFS_W-1:0] B0_LO_O   = OFS_W'(B0_RAM_LO);
    localparam logic [OFS_W-1:0] B1_HI_O   = OFS_W'(B1_RAM_HI);
    localparam logic [OFS_W-1:0] MIR_LO_O  = OFS_W'(MIRROR_LO);

    localparam logic [IDX_W-1:0] B0_LO_I   = IDX_W'(B0_RAM_LO);
    localparam logic [IDX_W-1:0] B1_BASE_I = IDX_W'(B0_SPAN - SFR_CNT);

    logic [IDX_W-1:0] ofs_i;
    assign ofs_i = IDX_W'(offset);

    // Bank 0 RAM packs at index 0; bank 1 private RAM follows it.
    // The bank 1 mirror window reuses the bank 0 index of the same offset.
    always_comb begin
        region  = RGN_NONE;
        ram_idx = '0;
        if (offset < SFR_END_O) begin
            region = RGN_SFR;
        end else if (!bank_sel) begin
            if (offset >= B0_LO_O) begin
                region  = RGN_RAM;
                ram_idx = ofs_i - B0_LO_I;
            end
        end else if (offset >= MIR_LO_O) begin
            region  = RGN_RAM;
            ram_idx = ofs_i - B0_LO_I;
        end else if (offset <= B1_HI_O) begin
            region  = RGN_RAM;
            ram_idx = ofs_i + B1_BASE_I;
        end
    end

endmodule

// File: rtl/dmem_gpr_ram.sv
module dmem_gpr_ram #(
    parameter int DEPTH  = 176,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // No reset: contents survive a reset of the core.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/dmem_bank_decoder.sv
module dmem_bank_decoder
    import dmem_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 7,
    parameter int SFR_CNT   = 32,
    parameter int B0_RAM_LO = 32,
    parameter int B1_RAM_HI = 111,
    parameter int MIRROR_LO = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic [OFS_W-1:0]  offset,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [OFS_W:0]    sfr_addr,
    output logic              sfr_wr_en,
    input  logic [DATA_W-1:0] sfr_rd_data
);

    localparam int OFS_SPAN = 1 << OFS_W;
    localparam int B0_SPAN  = OFS_SPAN - B0_RAM_LO;
    localparam int B1_SPAN  = B1_RAM_HI - SFR_CNT + 1;
    localparam int DEPTH    = B0_SPAN + B1_SPAN;
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    region_e           region;
    logic [IDX_W-1:0]  ram_idx;
    logic [DATA_W-1:0] ram_rdata;
    logic              wr_ok;
    logic              ram_we;

    dmem_addr_decode #(
        .OFS_W    (OFS_W),
        .SFR_CNT  (SFR_CNT),
        .B0_RAM_LO(B0_RAM_LO),
        .B1_RAM_HI(B1_RAM_HI),
        .MIRROR_LO(MIRROR_LO),
        .IDX_W    (IDX_W)
    ) dec_i (
        .bank_sel(bank_sel),
        .offset  (offset),
        .region  (region),
        .ram_idx (ram_idx)
    );

    dmem_gpr_ram #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) ram_i (
        .clk  (clk),
        .we   (ram_we),
        .idx  (ram_idx),
        .wdata(wr_data),
        .rdata(ram_rdata)
    );

    assign wr_ok     = wr_en & rst_n;
    assign ram_we    = wr_ok & (region == RGN_RAM);
    assign sfr_wr_en = wr_ok & (region == RGN_SFR);
    assign sfr_addr  = {bank_sel, offset};

    always_comb begin
        unique case (region)
            RGN_SFR: rd_data = sfr_rd_data;
            RGN_RAM: rd_data = ram_rdata;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dmem_bank_decoder_chk.sv
module dmem_bank_decoder_chk #(
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 7,
    parameter int SFR_CNT   = 32,
    parameter int B0_RAM_LO = 32,
    parameter int B1_RAM_HI = 111,
    parameter int MIRROR_LO = 112
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_sel,
    input logic [OFS_W-1:0]  offset,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              sfr_wr_en,
    input logic [DATA_W-1:0] sfr_rd_data
);

    localparam logic [OFS_W-1:0] SFR_END_O = OFS_W'(SFR_CNT);
    localparam logic [OFS_W-1:0] B0_LO_O   = OFS_W'(B0_RAM_LO);
    localparam logic [OFS_W-1:0] B1_HI_O   = OFS_W'(B1_RAM_HI);
    localparam logic [OFS_W-1:0] MIR_LO_O  = OFS_W'(MIRROR_LO);

    logic in_sfr, in_ram, in_hole;
    assign in_sfr  = offset < SFR_END_O;
    assign in_ram  = !in_sfr && (bank_sel ? (offset >= MIR_LO_O || offset <= B1_HI_O)
                                          : (offset >= B0_LO_O));
    assign in_hole = !in_sfr && !in_ram;

    AST_SFR_WE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr_en |-> in_sfr); // R2

    AST_SFR_RD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_sfr |-> rd_data == sfr_rd_data); // R2

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_hole |-> rd_data == '0); // R6

    AST_RAM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_ram) |=>
            (!$stable(bank_sel) || !$stable(offset) || rd_data == $past(wr_data))); // R3

    AST_MIRROR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_sel && offset >= MIR_LO_O) |=>
            (bank_sel || offset != $past(offset) || rd_data == $past(wr_data))); // R5

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_NO_WE_IN_RESET: assert (!sfr_wr_en); // R9
        end
    end

endmodule

bind dmem_bank_decoder dmem_bank_decoder_chk #(
    .DATA_W   (DATA_W),
    .OFS_W    (OFS_W),
    .SFR_CNT  (SFR_CNT),
    .B0_RAM_LO(B0_RAM_LO),
    .B1_RAM_HI(B1_RAM_HI),
    .MIRROR_LO(MIRROR_LO)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_sel   (bank_sel),
    .offset     (offset),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .sfr_wr_en  (sfr_wr_en),
    .sfr_rd_data(sfr_rd_data)
);

// File: tb/dmem_bank_decoder_tb_top.sv
`timescale 1ns/1ps
module dmem_bank_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_sel = 1'b0;
    logic [6:0] offset = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] sfr_rd_data;

    logic [7:0] rd_o [2];
    logic [7:0] sa_o [2];
    logic       swe_o [2];

    int nvec  = 0;
    int nfail = 0;
    bit done  = 0;

    logic [7:0] mdl [2][256];
    bit         vld [2][256];

    always #2.5 clk = ~clk;

    assign sfr_rd_data = {bank_sel, offset} ^ 8'hC3;

    dmem_bank_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .offset(offset),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_o[0]),
        .sfr_addr(sa_o[0]), .sfr_wr_en(swe_o[0]), .sfr_rd_data(sfr_rd_data)
    );

    // Reduced configuration: bank 0 RAM 40h-7Fh, bank 1 RAM A0h-CFh, holes elsewhere.
    dmem_bank_decoder #(.B0_RAM_LO(64), .B1_RAM_HI(79)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .offset(offset),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_o[1]),
        .sfr_addr(sa_o[1]), .sfr_wr_en(swe_o[1]), .sfr_rd_data(sfr_rd_data)
    );

    // 0 = SFR, 1 = RAM, 2 = hole
    function automatic int kind(int cfg, int a);
        int o, lo, hi;
        o  = a % 128;
        lo = (cfg == 0) ? 32 : 64;
        hi = (cfg == 0) ? 111 : 79;
        if (o < 32) return 0;
        if (a < 128) return (o >= lo) ? 1 : 2;
        if (o >= 112) return 1;
        return (o <= hi) ? 1 : 2;
    endfunction

    function automatic int canon(int a);
        return (a >= 240) ? a - 128 : a;
    endfunction

    function automatic string ram_req(int a);
        if (a >= 240 || (a >= 112 && a < 128)) return "R5";
        if (a >= 128) return "R4";
        return "R3";
    endfunction

    task automatic check(string req, int cfg, int a, logic [7:0] act, logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s cfg=%0d addr=%02h actual=%02h expected=%02h", req, cfg, a, act, exp);
        end
    endtask

    task automatic do_write(int a, logic [7:0] d);
        @(negedge clk);
        bank_sel = a[7];
        offset   = a[6:0];
        wr_data  = d;
        wr_en    = 1'b1;
        #1;
        for (int c = 0; c < 2; c++) begin
            check("R1", c, a, sa_o[c], a[7:0]);
            check("R2", c, a, {7'd0, swe_o[c]}, {7'd0, kind(c, a) == 0});
            if (kind(c, a) == 1 && vld[c][canon(a)])
                check("R8", c, a, rd_o[c], mdl[c][canon(a)]);
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c < 2; c++) begin
            if (kind(c, a) == 1) begin
                mdl[c][canon(a)] = d;
                vld[c][canon(a)] = 1'b1;
            end
        end
    endtask

    task automatic do_read(int a, string tag);
        @(negedge clk);
        bank_sel = a[7];
        offset   = a[6:0];
        wr_en    = 1'b0;
        #1;
        for (int c = 0; c < 2; c++) begin
            case (kind(c, a))
                0: check(tag == "" ? "R2" : tag, c, a, rd_o[c], sfr_rd_data);
                1: check(tag == "" ? ram_req(a) : tag, c, a, rd_o[c], mdl[c][canon(a)]);
                default: check(tag == "" ? "R6" : tag, c, a, rd_o[c], 8'h00);
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        // Reset state: SFR pass-through, hole returns zero, no SFR strobe (R9)
        repeat (3) @(negedge clk);
        bank_sel = 1'b0; offset = 7'h05; wr_en = 1'b1; wr_data = 8'hFF;
        #1;
        for (int c = 0; c < 2; c++) begin
            check("R9", c, 8'h05, {7'd0, swe_o[c]}, 8'h00);
            check("R2", c, 8'h05, rd_o[c], 8'h05 ^ 8'hC3);
        end
        bank_sel = 1'b1; offset = 7'h5A;
        #1;
        check("R6", 1, 8'hDA, rd_o[1], 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;

        // Ascending sweep: mirror window is last written from bank 1
        for (int a = 0; a < 256; a++) do_write(a, 8'((a * 7 + 3) & 255));
        for (int a = 0; a < 256; a++) do_read(a, "");

        // Descending sweep: bank 0 side of the alias written last
        for (int a = 255; a >= 0; a--) do_write(a, 8'((a * 13) ^ 8'hA5));
        for (int a = 0; a < 256; a++) do_read(a, "");

        // Alias in the other direction: write bank 1 window, read bank 0 (R5)
        do_write(8'hF7, 8'h3C);
        do_read(8'h77, "R5");
        do_write(8'h7A, 8'hC9);
        do_read(8'hFA, "R5");

        // Hole write leaves RAM and hole untouched (R7)
        do_write(8'hD5, 8'hEE);
        do_write(8'h25, 8'h11);
        do_read(8'hD5, "R7");
        do_read(8'h25, "R7");
        do_read(8'h40, "R7");
        do_read(8'hA0, "R7");

        // Writes during reset are dropped; RAM survives reset (R9, R10)
        @(negedge clk);
        rst_n = 1'b0;
        bank_sel = 1'b0; offset = 7'h50; wr_data = 8'h00; wr_en = 1'b1;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        do_read(8'h50, "R9");
        for (int a = 0; a < 256; a++) begin
            if (kind(0, a) == 1) do_read(a, "R10");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule